// File: doc/BRIEF.md
# Protection Unit Configuration Register Bank

This block holds the programmable settings of an eight-region bus protection unit. A simple synchronous register bus reads and writes it. A global control word carries a four-bit key field. One key code switches protection on, a second code switches it off, and every other code leaves the state alone. Protection is off after reset, so no filtering is requested until software enables it.

Each region has a base address, a size code with a region enable bit, and a three-bit access permission code. These three registers do not each get their own address per region. Software first writes a region number into a select register. The base, size/enable and permission registers of that region then appear at one shared set of offsets. The block drives the global enable and every region's stored settings straight out to the address checker, which lives outside this block.

Every access completes in a single cycle. Writes land on the clock edge that samples them. Read data is registered and shows on the read bus in the following cycle, where it stays until the next read.

Top module: `prot_cfg_regs`

## Requirements
- R1: After reset the protection enable output is 0, the control word reads 0x5, the region select reads 0, and every region has base 0, size 0, enable 0 and permission 000.
- R2: A write to offset 0x00 whose bits [3:0] equal 0xA sets the protection enable. A write whose bits [3:0] equal 0x5 clears it.
- R3: A write to offset 0x00 with any other value in bits [3:0] leaves the enable unchanged. Offset 0x00 reads 0xA in bits [3:0] when enabled and 0x5 when disabled, with all other bits zero.
- R4: The region select register at offset 0x04 stores bits [2:0] of the written data. Higher written bits are ignored and read as zero.
- R5: A write to offset 0x08, 0x0C or 0x10 changes only the region named by the region select register. All other regions keep their values.
- R6: Reads of offsets 0x08, 0x0C and 0x10 return the registers of the currently selected region.
- R7: Field layout. Base (0x08) stores bits [31:5], and bits [4:0] read zero. Size/enable (0x0C) has the region enable in bit 0 and a 5-bit size code in bits [5:1]. Access control (0x10) has the permission in bits [2:0]. All unlisted bits read zero.
- R8: The exported outputs carry, for each region r, its base in rgn_base_o[32r+31:32r], size in rgn_size_o[5r+4:5r], permission in rgn_perm_o[3r+2:3r] and enable in rgn_en_o[r]. They follow a write on the next clock edge.
- R9: A read (bus_sel=1, bus_wr=0) puts its data on bus_rdata after the next rising edge. bus_rdata then holds until the next read, and writes do not change it.
- R10: An access to any other offset, including one that is not word aligned, reads zero and its write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| prot_en_o | output | 1 | Global protection enable |
| rgn_en_o | output | 8 | Per-region enable |
| rgn_base_o | output | 256 | Per-region base address, 32 bits each |
| rgn_size_o | output | 40 | Per-region size code, 5 bits each |
| rgn_perm_o | output | 24 | Per-region permission code, 3 bits each |

## Verification
The hardest case to reach is a write through the shared offsets that leaks into a region other than the selected one. The stimulus first loads every region with a distinct pattern by stepping the select register through all eight values. It then reselects one middle region and rewrites it. The full exported bank is then compared, so a stray write enable on any neighbour shows up. Key writes with unused codes and unaligned writes carrying the enable code are used to show that these leave the enable state alone.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;

    // Word index of each register (byte offset divided by four)
    typedef enum logic [2:0] {
        WIDX_CTRL = 3'd0,
        WIDX_RSEL = 3'd1,
        WIDX_BASE = 3'd2,
        WIDX_SIZE = 3'd3,
        WIDX_ACC  = 3'd4
    } widx_e;

    localparam logic [3:0] KEY_CODE_ON  = 4'hA;
    localparam logic [3:0] KEY_CODE_OFF = 4'h5;

endpackage

// File: rtl/prot_cfg_ctrl.sv
module prot_cfg_ctrl #(
    parameter int NREG  = 8,
    parameter int KEY_W = 4,
    parameter int DATA_W = 32,
    parameter logic [KEY_W-1:0] KEY_ON  = 4'hA,
    parameter logic [KEY_W-1:0] KEY_OFF = 4'h5,
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_rsel,
    input  logic [DATA_W-1:0] wdata,
    output logic              en_o,
    output logic [KEY_W-1:0]  key_rd_o,
    output logic [SEL_W-1:0]  rsel_o
);

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] rsel;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [KEY_W-1:0] key_in;

    assign key_in = wdata[KEY_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            if (key_in == KEY_ON) begin
                st_d.en = 1'b1;
            end else if (key_in == KEY_OFF) begin
                st_d.en = 1'b0;
            end
        end
        if (wr_rsel) begin
            st_d.rsel = wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o     = st_q.en;
    assign key_rd_o = st_q.en ? KEY_ON : KEY_OFF;
    assign rsel_o   = st_q.rsel;

    AST_KEY_ON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && key_in == KEY_ON) |=> en_o); // R2
    AST_KEY_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && key_in == KEY_OFF) |=> !en_o); // R2
    AST_BAD_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && key_in != KEY_ON && key_in != KEY_OFF) |=> $stable(en_o)); // R3
    AST_IDLE_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(en_o)); // R3
    AST_RSEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rsel |=> $stable(rsel_o)); // R4

endmodule

// File: rtl/prot_cfg_region.sv
module prot_cfg_region #(
    parameter int DATA_W   = 32,
    parameter int BASE_LSB = 5,
    parameter int SIZE_W   = 5,
    parameter int PERM_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_base,
    input  logic              we_size,
    input  logic              we_acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              en_o,
    output logic [PERM_W-1:0] perm_o
);

    localparam int BHI_W = DATA_W - BASE_LSB;

    typedef struct packed {
        logic [BHI_W-1:0]  base;
        logic [SIZE_W-1:0] size;
        logic              en;
        logic [PERM_W-1:0] perm;
    } rgn_t;

    rgn_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_base) begin
            st_d.base = wdata[DATA_W-1:BASE_LSB];
        end
        if (we_size) begin
            st_d.en   = wdata[0];
            st_d.size = wdata[SIZE_W:1];
        end
        if (we_acc) begin
            st_d.perm = wdata[PERM_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o = {st_q.base, {BASE_LSB{1'b0}}};
    assign size_o = st_q.size;
    assign en_o   = st_q.en;
    assign perm_o = st_q.perm;

    AST_BASE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !we_base |=> $stable(base_o)); // R5
    AST_SIZE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !we_size |=> ($stable(size_o) && $stable(en_o))); // R5
    AST_PERM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !we_acc |=> $stable(perm_o)); // R5
    AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        base_o[BASE_LSB-1:0] == '0); // R7
    AST_BASE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        we_base |=> base_o[DATA_W-1:BASE_LSB] == $past(wdata[DATA_W-1:BASE_LSB])); // R7

endmodule

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs
    import prot_cfg_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int KEY_W    = 4,
    parameter int BASE_LSB = 5,
    parameter int SIZE_W   = 5,
    parameter int PERM_W   = 3,
    localparam int SEL_W   = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int WIDX_W  = ADDR_W - 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     prot_en_o,
    output logic [NREG-1:0]          rgn_en_o,
    output logic [NREG*DATA_W-1:0]   rgn_base_o,
    output logic [NREG*SIZE_W-1:0]   rgn_size_o,
    output logic [NREG*PERM_W-1:0]   rgn_perm_o
);

    localparam logic [WIDX_W-1:0] IDX_CTRL = WIDX_W'(WIDX_CTRL);
    localparam logic [WIDX_W-1:0] IDX_RSEL = WIDX_W'(WIDX_RSEL);
    localparam logic [WIDX_W-1:0] IDX_BASE = WIDX_W'(WIDX_BASE);
    localparam logic [WIDX_W-1:0] IDX_SIZE = WIDX_W'(WIDX_SIZE);
    localparam logic [WIDX_W-1:0] IDX_ACC  = WIDX_W'(WIDX_ACC);

    // ---------------- address decode ----------------
    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic hit_ctrl, hit_rsel, hit_base, hit_size, hit_acc, mapped;
    logic do_wr, do_rd;

    assign widx     = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign hit_ctrl = aligned && (widx == IDX_CTRL);
    assign hit_rsel = aligned && (widx == IDX_RSEL);
    assign hit_base = aligned && (widx == IDX_BASE);
    assign hit_size = aligned && (widx == IDX_SIZE);
    assign hit_acc  = aligned && (widx == IDX_ACC);
    assign mapped   = hit_ctrl || hit_rsel || hit_base || hit_size || hit_acc;
    assign do_wr    = bus_sel && bus_wr;
    assign do_rd    = bus_sel && !bus_wr;

    // ---------------- global control ----------------
    logic             en;
    logic [KEY_W-1:0] key_rd;
    logic [SEL_W-1:0] rsel;

    prot_cfg_ctrl #(
        .NREG   (NREG),
        .KEY_W  (KEY_W),
        .DATA_W (DATA_W),
        .KEY_ON (KEY_CODE_ON),
        .KEY_OFF(KEY_CODE_OFF)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (do_wr && hit_ctrl),
        .wr_rsel (do_wr && hit_rsel),
        .wdata   (bus_wdata),
        .en_o    (en),
        .key_rd_o(key_rd),
        .rsel_o  (rsel)
    );

    assign prot_en_o = en;

    // ---------------- region storage ----------------
    logic [NREG-1:0]   we_base_v, we_size_v, we_acc_v;
    logic [DATA_W-1:0] base_arr [NREG];
    logic [SIZE_W-1:0] size_arr [NREG];
    logic [PERM_W-1:0] perm_arr [NREG];
    logic [NREG-1:0]   en_arr;

    for (genvar r = 0; r < NREG; r++) begin : g_rgn
        logic sel_me;
        assign sel_me       = (rsel == SEL_W'(r));
        assign we_base_v[r] = do_wr && hit_base && sel_me;
        assign we_size_v[r] = do_wr && hit_size && sel_me;
        assign we_acc_v[r]  = do_wr && hit_acc  && sel_me;

        prot_cfg_region #(
            .DATA_W  (DATA_W),
            .BASE_LSB(BASE_LSB),
            .SIZE_W  (SIZE_W),
            .PERM_W  (PERM_W)
        ) rgn_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_base(we_base_v[r]),
            .we_size(we_size_v[r]),
            .we_acc (we_acc_v[r]),
            .wdata  (bus_wdata),
            .base_o (base_arr[r]),
            .size_o (size_arr[r]),
            .en_o   (en_arr[r]),
            .perm_o (perm_arr[r])
        );

        assign rgn_base_o[r*DATA_W +: DATA_W] = base_arr[r];
        assign rgn_size_o[r*SIZE_W +: SIZE_W] = size_arr[r];
        assign rgn_perm_o[r*PERM_W +: PERM_W] = perm_arr[r];
    end

    assign rgn_en_o = en_arr;

    // ---------------- registered read path ----------------
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (do_rd) begin
            rd_d.rdata = '0;
            if (hit_ctrl) begin
                rd_d.rdata[KEY_W-1:0] = key_rd;
            end else if (hit_rsel) begin
                rd_d.rdata[SEL_W-1:0] = rsel;
            end else if (hit_base) begin
                rd_d.rdata = base_arr[rsel];
            end else if (hit_size) begin
                rd_d.rdata[SIZE_W:0] = {size_arr[rsel], en_arr[rsel]};
            end else if (hit_acc) begin
                rd_d.rdata[PERM_W-1:0] = perm_arr[rsel];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;

    AST_ONE_BASE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_base_v)); // R5
    AST_ONE_SIZE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_size_v)); // R5
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && !mapped) |=> (bus_rdata == '0)); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !do_rd |=> $stable(bus_rdata)); // R9
    AST_CTRL_READ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && hit_ctrl) |=> (bus_rdata == DATA_W'(prot_en_o ? KEY_CODE_ON : KEY_CODE_OFF))); // R3

endmodule

// File: tb/prot_cfg_regs_tb.sv
module prot_cfg_regs_tb_top;

    localparam int NREG = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         prot_en_o;
    logic [7:0]   rgn_en_o;
    logic [255:0] rgn_base_o;
    logic [39:0]  rgn_size_o;
    logic [23:0]  rgn_perm_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] exp_base [NREG];
    logic [4:0]  exp_size [NREG];
    logic        exp_en   [NREG];
    logic [2:0]  exp_perm [NREG];

    always #5 clk = ~clk;

    prot_cfg_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prot_en_o(prot_en_o), .rgn_en_o(rgn_en_o), .rgn_base_o(rgn_base_o),
        .rgn_size_o(rgn_size_o), .rgn_perm_o(rgn_perm_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_bank(input string req);
        for (int r = 0; r < NREG; r++) begin
            check(req, rgn_base_o[r*32 +: 32], exp_base[r]);
            check(req, 32'(rgn_size_o[r*5 +: 5]), 32'(exp_size[r]));
            check(req, 32'(rgn_en_o[r]), 32'(exp_en[r]));
            check(req, 32'(rgn_perm_o[r*3 +: 3]), 32'(exp_perm[r]));
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int r = 0; r < NREG; r++) begin
            exp_base[r] = '0; exp_size[r] = '0; exp_en[r] = 1'b0; exp_perm[r] = '0;
        end
        check("R1 enable after reset", 32'(prot_en_o), 32'd0);
        check_bank("R1 region reset");
        bus_read(8'h00, d); check("R1 ctrl read", d, 32'h5);
        bus_read(8'h04, d); check("R1 rsel read", d, 32'h0);
        bus_read(8'h08, d); check("R1 base read", d, 32'h0);
    endtask

    task automatic t_key;
        logic [31:0] d;
        bus_write(8'h00, 32'h0000_000A);
        check("R2 key A enables", 32'(prot_en_o), 32'd1);
        bus_read(8'h00, d); check("R3 ctrl reads A", d, 32'hA);
        bus_write(8'h00, 32'h0000_0003);
        check("R3 bad key 3 holds", 32'(prot_en_o), 32'd1);
        bus_write(8'h00, 32'hFFFF_FFF0);
        check("R3 bad key 0 holds", 32'(prot_en_o), 32'd1);
        bus_write(8'h00, 32'h1234_5675);
        check("R2 key 5 disables", 32'(prot_en_o), 32'd0);
        bus_read(8'h00, d); check("R3 ctrl reads 5", d, 32'h5);
        bus_write(8'h00, 32'h0000_00AF);
        check("R3 bad key F holds off", 32'(prot_en_o), 32'd0);
    endtask

    task automatic t_rsel;
        logic [31:0] d;
        bus_write(8'h04, 32'hFFFF_FFFB);
        bus_read(8'h04, d); check("R4 rsel upper bits dropped", d, 32'h3);
    endtask

    task automatic t_regions;
        logic [31:0] d;
        for (int r = 0; r < NREG; r++) begin
            bus_write(8'h04, 32'(r));
            bus_write(8'h08, 32'h8000_001F + 32'(r) * 32'h0101_0020);
            bus_write(8'h0C, 32'hFFFF_FFC0 | (32'(r + 20) << 1) | 32'(r & 1));
            bus_write(8'h10, 32'hFFFF_FFF8 | 32'(7 - r));
            exp_base[r] = (32'h8000_001F + 32'(r) * 32'h0101_0020) & 32'hFFFF_FFE0;
            exp_size[r] = 5'(r + 20);
            exp_en[r]   = 1'((r & 1) != 0);
            exp_perm[r] = 3'(7 - r);
        end
        check_bank("R8 exports after load");
        for (int r = 0; r < NREG; r++) begin
            bus_write(8'h04, 32'(r));
            bus_read(8'h08, d); check("R6 R7 base readback", d, exp_base[r]);
            bus_read(8'h0C, d);
            check("R6 R7 size readback", d, {26'd0, exp_size[r], exp_en[r]});
            bus_read(8'h10, d); check("R6 R7 perm readback", d, {29'd0, exp_perm[r]});
        end
        bus_write(8'h04, 32'h2);
        bus_write(8'h08, 32'h0000_0040);
        bus_write(8'h0C, 32'h0000_0001);
        bus_write(8'h10, 32'h0000_0006);
        exp_base[2] = 32'h0000_0040; exp_size[2] = 5'd0; exp_en[2] = 1'b1; exp_perm[2] = 3'd6;
        check_bank("R5 only selected region changes");
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        bus_write(8'h01, 32'h0000_000A);
        check("R10 unaligned key write dropped", 32'(prot_en_o), 32'd0);
        bus_write(8'h09, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'hFC, 32'hFFFF_FFFF);
        check_bank("R10 unmapped writes dropped");
        bus_read(8'h04, d); check("R10 rsel unchanged", d, 32'h2);
        bus_read(8'h14, d); check("R10 read 0x14 zero", d, 32'h0);
        bus_read(8'h0A, d); check("R10 unaligned read zero", d, 32'h0);
    endtask

    task automatic t_rdhold;
        logic [31:0] d;
        bus_read(8'h08, d); check("R9 read data", d, 32'h0000_0040);
        repeat (3) @(negedge clk);
        check("R9 idle holds", bus_rdata, 32'h0000_0040);
        bus_write(8'h10, 32'h0000_0001);
        exp_perm[2] = 3'd1;
        check("R9 write does not disturb rdata", bus_rdata, 32'h0000_0040);
        check("R8 perm export", 32'(rgn_perm_o[2*3 +: 3]), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_key();
        t_rsel();
        t_regions();
        t_unmapped();
        t_rdhold();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule